// File: doc/BRIEF.md
# GPIO Register Bank Controller

This block is a register-mapped general-purpose I/O controller for up to 54 pins, seen by software as a flat set of 32-bit words. Every pin has a three-bit function code, packed ten to a word. The non-sequential alternate-function encoding is kept exactly, because pad logic elsewhere decodes it. Output levels never change through a read-modify-write. Software writes ones to a set bank or a clear bank, and zeros in those writes do nothing. Input levels pass through a two-flop synchronizer and are read back from two level banks.

Pull-up or pull-down selection is applied per pin by a clocked sequence. Software writes a two-bit pull mode, waits, raises the pull-clock bits of the chosen pins, waits again and drops them. A small state machine in the pull unit moves from `PL_IDLE` to `PL_APPLY` (transition *arm*) when any pull-clock bit is set. It moves back to `PL_IDLE` (transition *release*) when all of them are clear. While it is in `PL_APPLY`, every pin whose pull-clock bit is set copies the current pull mode. With no bit set it stays in `PL_IDLE` (transition *wait*), and with bits still set it stays in `PL_APPLY` (transition *hold*).

The bus port has a byte address, write data, a write strobe and a read strobe. Read data is registered and holds its value between reads. The pin side gives each pin an output value, an output enable, its function code and its pull setting.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every function code is 000 (input), every output latch is 0, every output enable is 0, every pull setting is 00 (none), and the read data is 0.
- R2: The function code of pin n is stored in word n/10 (byte offset 4*(n/10), words at 0x00 to 0x14), bits 3*(n%10)+2 down to 3*(n%10). It drives `pin_func[3n+2:3n]` and reads back in place. Word bits 31:30 read as zero.
- R3: The function codes are 000 input, 001 output, 100 alt0, 101 alt1, 110 alt2, 111 alt3, 011 alt4 and 010 alt5. A pin's output enable is 1 only while its code is 001, and its driven value is its output latch.
- R4: Writing a 1 to bit n%32 of set bank n/32 (0x1C for pins 0 to 31, 0x20 for pins 32 to 53) sets pin n's output latch. Zero bits leave latches unchanged, and both set banks read as zero.
- R5: Writing a 1 to bit n%32 of clear bank n/32 (0x28 and 0x2C) clears pin n's output latch. Zero bits leave latches unchanged, and both clear banks read as zero.
- R6: Level bank n/32 (0x34 and 0x38, read-only) returns the input of pin n in bit n%32 after two synchronizer stages. A read issued in the same cycle that the input changes returns the old level.
- R7: The pull mode sits in bits 1:0 of 0x94 (00 none, 01 down, 10 up). The pull-clock banks sit at 0x98 and 0x9C, with pin n at bit n%32 of bank n/32. Once `PL_APPLY` is reached, each pin whose pull-clock bit is set takes the pull mode. A pin whose bit is 0 keeps its setting, and all three words read back.
- R8: Reserved words (0x18, 0x24, 0x30, 0x3C, 0x40 to 0x90, above 0x9C) and any address with nonzero bits 1:0 read as zero and ignore writes.
- R9: In the upper banks (0x20, 0x2C, 0x38, 0x9C), bits 31:22 name no pin. They are ignored on write and read as zero, and so are the unused bits of function word 0x14 above bit 11.
- R10: A read strobe loads the read data at the next clock edge. Without a read strobe the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 54 | Raw input level of each pin |
| pin_out | output | 54 | Output latch of each pin |
| pin_oe | output | 54 | Output enable of each pin |
| pin_func | output | 162 | Three-bit function code per pin |
| pin_pull | output | 108 | Two-bit pull setting per pin |

## Verification
The bench targets field placement at the word edges. Pin 30 lands in word 3 while bits 31:30 must vanish, and pin 53 ends word 5 at bit 11. A slip in the divide or modulo would move codes to the wrong pin or leak upper bits. It drives every alternate code through one word, because a decoder that enabled the output on any nonzero code would light extra enables. It writes set and clear banks with zero bits and with ones above pin 53, which exposes any decoder that treats the banks as plain stores or wraps the pin index. It also reads a level in the same cycle that the input changes to prove both synchronizer stages exist. Finally, it changes the pull mode with no clock bit raised, which a design that applies the mode continuously would get wrong.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W      = 8;
    localparam int WIDX_W      = ADDR_W - 2;
    localparam int WORD_W      = 32;
    localparam int FN_W        = 3;
    localparam int FN_PER_WORD = 10;
    localparam int PULL_W      = 2;

    // Word indexes (byte offset / 4); bank 1 of each pair is base + 1.
    localparam logic [WIDX_W-1:0] W_SET0  = 6'd7;
    localparam logic [WIDX_W-1:0] W_CLR0  = 6'd10;
    localparam logic [WIDX_W-1:0] W_LEV0  = 6'd13;
    localparam logic [WIDX_W-1:0] W_PULL  = 6'd37;
    localparam logic [WIDX_W-1:0] W_PCLK0 = 6'd38;

    typedef enum logic [2:0] {
        FN_INPUT  = 3'b000,
        FN_OUTPUT = 3'b001,
        FN_ALT5   = 3'b010,
        FN_ALT4   = 3'b011,
        FN_ALT0   = 3'b100,
        FN_ALT1   = 3'b101,
        FN_ALT2   = 3'b110,
        FN_ALT3   = 3'b111
    } gpio_fn_e;

    typedef enum logic [0:0] {
        PL_IDLE  = 1'b0,
        PL_APPLY = 1'b1
    } pull_state_e;

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int WIDTH = 54
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage1_q <= '0;
        else        stage1_q <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage2_q <= '0;
        else        stage2_q <= stage1_q;
    end

    assign q = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stage1_q) == stage2_q); // R6
endmodule

// File: rtl/gpio_fsel.sv
module gpio_fsel
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WIDX_W-1:0]             wr_word,
    input  logic [FN_PER_WORD*FN_W-1:0]   wr_data,
    input  logic [WIDX_W-1:0]             rd_word,
    output logic [WORD_W-1:0]             rd_data,
    output logic [NUM_PINS*FN_W-1:0]      fn_flat
);
    localparam int FSEL_WORDS = (NUM_PINS + FN_PER_WORD - 1) / FN_PER_WORD;

    logic [NUM_PINS*FN_W-1:0] fn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) fn_q[p*FN_W +: FN_W] <= FN_INPUT;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_word == WIDX_W'(p / FN_PER_WORD))
                    fn_q[p*FN_W +: FN_W] <= wr_data[(p % FN_PER_WORD)*FN_W +: FN_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_word == WIDX_W'(p / FN_PER_WORD))
                rd_data[(p % FN_PER_WORD)*FN_W +: FN_W] = fn_q[p*FN_W +: FN_W];
        end
    end

    assign fn_flat = fn_q;

    AST_FSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_word < WIDX_W'(FSEL_WORDS))) |=> $stable(fn_q)); // R8
endmodule

// File: rtl/gpio_pull.sv
module gpio_pull
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDX_W-1:0]          wr_word,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [WIDX_W-1:0]          rd_word,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_PINS*PULL_W-1:0] pull_flat
);
    logic [PULL_W-1:0]          mode_q;
    logic [NUM_PINS-1:0]        pclk_q;
    logic [NUM_PINS*PULL_W-1:0] pull_q;
    pull_state_e                state_q;
    pull_state_e                state_d;

    // Software-visible mode and clock words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            pclk_q <= '0;
        end else if (wr_en) begin
            if (wr_word == W_PULL) mode_q <= wr_data[PULL_W-1:0];
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_word == WIDX_W'(W_PCLK0 + WIDX_W'(p / WORD_W)))
                    pclk_q[p] <= wr_data[p % WORD_W];
            end
        end
    end

    // Next-state logic: wait / arm / hold / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PL_IDLE:  if (|pclk_q)    state_d = PL_APPLY;
            PL_APPLY: if (pclk_q == '0) state_d = PL_IDLE;
            default:  state_d = PL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PL_IDLE;
        else        state_q <= state_d;
    end

    // Output process: latch pull settings while applying
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= '0;
        end else begin
            unique case (state_q)
                PL_APPLY: begin
                    for (int p = 0; p < NUM_PINS; p++)
                        if (pclk_q[p]) pull_q[p*PULL_W +: PULL_W] <= mode_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_word == W_PULL) rd_data[PULL_W-1:0] = mode_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_word == WIDX_W'(W_PCLK0 + WIDX_W'(p / WORD_W)))
                rd_data[p % WORD_W] = pclk_q[p];
        end
    end

    assign pull_flat = pull_q;

    AST_PULL_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PL_IDLE) |=> $stable(pull_q)); // R7
    AST_PULL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PL_IDLE && |pclk_q) |=> (state_q == PL_APPLY)); // R7
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS-1:0]        pin_oe,
    output logic [NUM_PINS*FN_W-1:0]   pin_func,
    output logic [NUM_PINS*PULL_W-1:0] pin_pull
);
    logic              addr_ok;
    logic [WIDX_W-1:0] word;
    logic              wr_en;
    logic [WORD_W-1:0] fsel_rd;
    logic [WORD_W-1:0] pull_rd;
    logic [WORD_W-1:0] lev_rd;
    logic [NUM_PINS-1:0] lev_sync;
    logic [NUM_PINS-1:0] out_q;
    logic [WORD_W-1:0] rdata_q;

    assign addr_ok = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[ADDR_W-1:2];
    assign wr_en   = bus_we && addr_ok;

    gpio_fsel #(.NUM_PINS(NUM_PINS)) u_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (word),
        .wr_data (bus_wdata[FN_PER_WORD*FN_W-1:0]),
        .rd_word (word),
        .rd_data (fsel_rd),
        .fn_flat (pin_func)
    );

    gpio_pull #(.NUM_PINS(NUM_PINS)) u_pull (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (word),
        .wr_data   (bus_wdata),
        .rd_word   (word),
        .rd_data   (pull_rd),
        .pull_flat (pin_pull)
    );

    gpio_insync #(.WIDTH(NUM_PINS)) u_insync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lev_sync)
    );

    // Output latches: write-one-to-set / write-one-to-clear banks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (word == WIDX_W'(W_SET0 + WIDX_W'(p / WORD_W)) && bus_wdata[p % WORD_W])
                    out_q[p] <= 1'b1;
                else if (word == WIDX_W'(W_CLR0 + WIDX_W'(p / WORD_W)) && bus_wdata[p % WORD_W])
                    out_q[p] <= 1'b0;
            end
        end
    end

    // Level banks
    always_comb begin
        lev_rd = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (word == WIDX_W'(W_LEV0 + WIDX_W'(p / WORD_W)))
                lev_rd[p % WORD_W] = lev_sync[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= addr_ok ? (fsel_rd | pull_rd | lev_rd) : '0;
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_oe
            assign pin_oe[g] = (pin_func[g*FN_W +: FN_W] == FN_OUTPUT);
        end
    endgenerate

    assign pin_out   = out_q;
    assign bus_rdata = rdata_q;

    // Independent decode of the reserved space for checking
    logic chk_resv;
    always_comb begin
        chk_resv = (bus_addr[1:0] != 2'b00) || (bus_addr == 8'h18) || (bus_addr == 8'h24)
                || (bus_addr == 8'h30) || (bus_addr == 8'h3C)
                || (bus_addr >= 8'h40 && bus_addr <= 8'h90) || (bus_addr > 8'h9C);
    end

    AST_SET_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h1C && bus_wdata[0]) |=> pin_out[0]); // R4
    AST_CLR_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h28 && bus_wdata[0]) |=> !pin_out[0]); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == 8'h1C || bus_addr == 8'h20 || bus_addr == 8'h28 || bus_addr == 8'h2C))
        |=> $stable(pin_out)); // R4
    AST_RESV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && chk_resv) |=> (bus_rdata == '0)); // R8
    AST_LEV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 8'h38) |=> (bus_rdata[31:22] == '0)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 54;

    logic          clk;
    logic          rst_n;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_we;
    logic          bus_re;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP*3-1:0] pin_func;
    logic [NP*2-1:0] pin_pull;

    int n_run  = 0;
    int n_fail = 0;

    gpio_regbank #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .pin_pull(pin_pull)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0000_0108, 8'd2},  // R2 pin1=001, pin2=100
        '{1'b1, 8'h00, 32'h0000_0108, 8'd2},  // R2 read back in place
        '{1'b0, 8'h14, 32'hFFFF_FFFF, 8'd9},
        '{1'b1, 8'h14, 32'h0000_0FFF, 8'd9},  // R9 only pins 50..53 exist
        '{1'b0, 8'h0C, 32'hC000_0005, 8'd2},
        '{1'b1, 8'h0C, 32'h0000_0005, 8'd2},  // R2 bits 31:30 read zero
        '{1'b0, 8'h1C, 32'h0000_0002, 8'd4},
        '{1'b1, 8'h1C, 32'h0000_0000, 8'd4},  // R4 set bank reads zero
        '{1'b0, 8'h2C, 32'hFFFF_FFFF, 8'd5},
        '{1'b1, 8'h2C, 32'h0000_0000, 8'd5},  // R5 clear bank reads zero
        '{1'b0, 8'h94, 32'h0000_0002, 8'd7},
        '{1'b1, 8'h94, 32'h0000_0002, 8'd7},  // R7 mode reads back
        '{1'b0, 8'h40, 32'hFFFF_FFFF, 8'd8},
        '{1'b1, 8'h40, 32'h0000_0000, 8'd8},  // R8 reserved reads zero
        '{1'b0, 8'h9C, 32'hFFFF_FFFF, 8'd9},
        '{1'b1, 8'h9C, 32'h003F_FFFF, 8'd9},  // R9 upper pull-clock bits zero
        '{1'b0, 8'h01, 32'hFFFF_FFFF, 8'd8},  // R8 misaligned write ignored
        '{1'b1, 8'h00, 32'h0000_0108, 8'd8}   // R8 function word untouched
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0; pin_in = '0;
        rst_n = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", {32'd0, bus_rdata}, 64'd0);
        do_reset();
        check("R1 func", {63'd0, |pin_func}, 64'd0);
        check("R1 out",  {10'd0, pin_out}, 64'd0);
        check("R1 oe",   {10'd0, pin_oe}, 64'd0);
        check("R1 pull", {63'd0, |pin_pull}, 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                bus_rd(VEC[i].addr, rd);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), {32'd0, rd}, {32'd0, VEC[i].data});
            end else begin
                bus_wr(VEC[i].addr, VEC[i].data);
            end
        end

        // Set / clear / output enable
        do_reset();
        bus_wr(8'h00, 32'h0000_0008);
        check("R3 oe pin1", {63'd0, pin_oe[1]}, 64'd1);
        check("R3 out pin1 before set", {63'd0, pin_out[1]}, 64'd0);
        bus_wr(8'h1C, 32'h0000_0002);
        check("R4 set pin1", {63'd0, pin_out[1]}, 64'd1);
        bus_wr(8'h1C, 32'h0000_0000);
        check("R4 zero write no effect", {10'd0, pin_out}, 64'h2);
        bus_wr(8'h20, 32'h0000_0008);
        check("R4 set pin35", {10'd0, pin_out}, (64'd1 << 35) | 64'h2);
        check("R3 oe pin35 input", {63'd0, pin_oe[35]}, 64'd0);
        bus_wr(8'h28, 32'h0000_0002);
        check("R5 clear pin1 only", {10'd0, pin_out}, 64'd1 << 35);
        bus_wr(8'h2C, 32'h0000_0000);
        check("R5 zero clear no effect", {10'd0, pin_out}, 64'd1 << 35);
        bus_wr(8'h20, 32'hFFC0_0000);
        check("R9 set above pin53", {10'd0, pin_out}, 64'd1 << 35);
        bus_wr(8'h2C, 32'h0000_0008);
        check("R5 clear pin35", {10'd0, pin_out}, 64'd0);

        // Every code in one word: p0..p7 = alt0,alt1,alt2,alt3,alt4,alt5,input,output
        bus_wr(8'h00, (32'd4) | (32'd5 << 3) | (32'd6 << 6) | (32'd7 << 9)
                    | (32'd3 << 12) | (32'd2 << 15) | (32'd0 << 18) | (32'd1 << 21));
        check("R3 oe only for output code", {56'd0, pin_oe[7:0]}, 64'h80);
        check("R2 pin0 code alt0", {61'd0, pin_func[2:0]}, 64'd4);
        check("R2 pin4 code alt4", {61'd0, pin_func[14:12]}, 64'd3);
        bus_wr(8'h14, 32'h0000_0200);
        check("R2 pin53 code", {61'd0, pin_func[161:159]}, 64'd1);
        check("R3 pin53 oe", {63'd0, pin_oe[53]}, 64'd1);

        // Level banks through synchronizer
        pin_in = (54'd1 << 1) | (54'd1 << 35) | (54'd1 << 53);
        bus_rd(8'h34, rd);
        check("R6 same-cycle read returns old", {32'd0, rd}, 64'd0);
        repeat (2) @(negedge clk);
        bus_rd(8'h34, rd);
        check("R6 level bank0", {32'd0, rd}, 64'h2);
        bus_rd(8'h38, rd);
        check("R6 level bank1", {32'd0, rd}, 64'h0020_0008);
        pin_in = '1;
        repeat (3) @(negedge clk);
        bus_rd(8'h38, rd);
        check("R9 level upper bits zero", {32'd0, rd}, 64'h003F_FFFF);

        // Pull sequence
        do_reset();
        bus_wr(8'h94, 32'h0000_0001);
        repeat (3) @(negedge clk);
        check("R7 mode alone no change", {63'd0, |pin_pull}, 64'd0);
        bus_wr(8'h98, 32'h0000_0004);
        repeat (3) @(negedge clk);
        check("R7 pin2 pulled down", {62'd0, pin_pull[5:4]}, 64'd1);
        check("R7 pin0 untouched", {62'd0, pin_pull[1:0]}, 64'd0);
        check("R7 pin3 untouched", {62'd0, pin_pull[7:6]}, 64'd0);
        bus_wr(8'h98, 32'h0000_0000);
        bus_wr(8'h94, 32'h0000_0002);
        repeat (3) @(negedge clk);
        check("R7 clock cleared holds", {62'd0, pin_pull[5:4]}, 64'd1);
        bus_wr(8'h9C, 32'h0020_0000);
        repeat (3) @(negedge clk);
        check("R7 pin53 pulled up", {62'd0, pin_pull[107:106]}, 64'd2);
        check("R7 pin2 kept", {62'd0, pin_pull[5:4]}, 64'd1);
        bus_wr(8'h9C, 32'h0000_0000);

        // Read data hold
        bus_rd(8'h94, rd);
        check("R10 read mode", {32'd0, rd}, 64'd2);
        bus_addr = 8'h00;
        repeat (2) @(negedge clk);
        check("R10 rdata holds without strobe", {32'd0, bus_rdata}, 64'd2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule